// File: doc/BRIEF.md
# Timer Output Compare Channel

This block is a single compare channel attached to a free-running up-counter. Each cycle it compares the counter with a compare register. From that comparison and a 3-bit mode field it drives one output level and raises a sticky event flag. The compare register can be written directly, or through a shadow copy that moves into the active register only on an update event. An update event is either the counter wrapping or a software update request.

Two kinds of comparison coexist. The match modes act only on exact equality, so a compare value that the counter has already passed is missed until the count comes round again. The two PWM modes use a magnitude test on every cycle, so a late value still takes effect at once. The event flag follows equality in every mode, including PWM.

The output level is held in a two-state machine: `LVL_INACTIVE` (output low) and `LVL_ACTIVE` (output high). On each clock the mode and comparison choose one of four transitions:
- `TR_HOLD` keeps the state.
- `TR_SET` enters `LVL_ACTIVE`.
- `TR_CLEAR` enters `LVL_INACTIVE`.
- `TR_FLIP` enters the other state.

Top module: `oc_channel`

## Requirements
- R1: The counter resets to 0. It increments by one per clock and goes to 0 on the clock after it equals `arr_i`. That wrap is an update event.
- R2: While reset is asserted, the counter reads 0, the compare register reads all ones, and the output, flag and interrupt are low.
- R3: In mode 3'b001 the output goes high one clock after a cycle in which the count equals the compare value, and otherwise holds. A compare value written below the current count leaves the output unchanged until the counter wraps round to that value.
- R4: In mode 3'b010 the output goes low one clock after a cycle of equality, and otherwise holds.
- R5: In mode 3'b011 the output inverts one clock after each cycle of equality, and otherwise holds.
- R6: Mode 3'b101 drives the output high and mode 3'b100 drives it low on the next clock, whatever the count and compare values are. A mode change always takes effect on the next clock.
- R7: In mode 3'b000 the output holds its last level, including across equality cycles.
- R8: In mode 3'b110 the output on each clock is high when the previous cycle's count was below the compare value, and low otherwise.
- R9: In mode 3'b111 the output on each clock is low when the previous cycle's count was below the compare value, and high otherwise. A compare value written below the current count asserts the output one clock after the register takes it, and does not set the flag.
- R10: The flag is set one clock after any cycle in which the count equals the compare value, whatever the mode. It stays set until a `flag_clr_i` pulse clears it. If a set and a clear fall in the same cycle, the set wins.
- R11: `irq_o` is high exactly when the flag and `irq_en_i` are both high.
- R12: With `preload_en_i` high, a write changes only the shadow copy. The active compare value takes the shadow on an update event. With `preload_en_i` low, a write changes the active value on the next clock.
- R13: A `sw_update_i` pulse sets the counter to 0 on the next clock and loads the shadow into the active compare register when preload is on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| arr_i | input | 16 | Auto-reload value, the top count before wrap |
| mode_i | input | 3 | Output mode select |
| preload_en_i | input | 1 | Route compare writes through the shadow copy |
| cmp_wr_i | input | 1 | Compare write strobe |
| cmp_wdata_i | input | 16 | Compare write data |
| sw_update_i | input | 1 | Software update request |
| flag_clr_i | input | 1 | Event flag clear strobe (write one to clear) |
| irq_en_i | input | 1 | Interrupt enable |
| cnt_o | output | 16 | Current count |
| cmp_o | output | 16 | Active compare value |
| oc_out_o | output | 1 | Compare output level |
| flag_o | output | 1 | Sticky compare event flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The checker covers the per-cycle rules on every clock:
- counter stepping and wrapping;
- the flag setting only on equality;
- the output holding in frozen mode and in the match modes when there is no equality;
- the forced levels;
- the PWM magnitude relation;
- the active compare value staying put under preload between update events.

Only the bench's scenarios can show the order-dependent stories. These are a compare value written behind the count being missed until the wrap, a late PWM write asserting without a flag, and a shadow value arriving on a wrap or on a software update.

// File: rtl/oc_pkg.sv
package oc_pkg;

    typedef enum logic [2:0] {
        MODE_FROZEN      = 3'b000,
        MODE_ACT_MATCH   = 3'b001,
        MODE_INACT_MATCH = 3'b010,
        MODE_TOGGLE      = 3'b011,
        MODE_FORCE_LO    = 3'b100,
        MODE_FORCE_HI    = 3'b101,
        MODE_PWM_A       = 3'b110,
        MODE_PWM_B       = 3'b111
    } oc_mode_e;

    typedef enum logic {
        LVL_INACTIVE = 1'b0,
        LVL_ACTIVE   = 1'b1
    } lvl_state_e;

    typedef enum logic [1:0] {
        TR_HOLD  = 2'b00,
        TR_SET   = 2'b01,
        TR_CLEAR = 2'b10,
        TR_FLIP  = 2'b11
    } lvl_trans_e;

endpackage

// File: rtl/oc_upcnt.sv
module oc_upcnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] arr_i,
    input  logic         sw_upd_i,
    output logic [W-1:0] cnt_o,
    output logic         upd_o
);

    logic at_top;

    assign at_top = (cnt_o == arr_i);
    assign upd_o  = sw_upd_i | at_top;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_o <= '0;
        end else if (upd_o) begin
            cnt_o <= '0;
        end else begin
            cnt_o <= cnt_o + 1'b1;
        end
    end

endmodule

// File: rtl/oc_cmp_reg.sv
module oc_cmp_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    input  logic         preload_i,
    input  logic         upd_i,
    output logic [W-1:0] active_o
);

    localparam logic [W-1:0] RST_VAL = {W{1'b1}};

    logic [W-1:0] shadow_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow_q <= RST_VAL;
        end else if (wr_i) begin
            shadow_q <= wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_o <= RST_VAL;
        end else if (!preload_i) begin
            if (wr_i) begin
                active_o <= wdata_i;
            end
        end else if (upd_i) begin
            active_o <= wr_i ? wdata_i : shadow_q;
        end
    end

endmodule

// File: rtl/oc_lvl_fsm.sv
module oc_lvl_fsm
    import oc_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  oc_mode_e     mode_i,
    input  logic [W-1:0] cnt_i,
    input  logic [W-1:0] cmp_i,
    input  logic         match_i,
    output logic         level_o
);

    lvl_state_e state_q;
    lvl_state_e state_nx;
    lvl_trans_e trans;
    logic       below;

    assign below = (cnt_i < cmp_i);

    // Transition choice from mode and comparison
    always_comb begin
        trans = TR_HOLD;
        unique case (mode_i)
            MODE_FROZEN:      trans = TR_HOLD;
            MODE_ACT_MATCH:   trans = match_i ? TR_SET   : TR_HOLD;
            MODE_INACT_MATCH: trans = match_i ? TR_CLEAR : TR_HOLD;
            MODE_TOGGLE:      trans = match_i ? TR_FLIP  : TR_HOLD;
            MODE_FORCE_LO:    trans = TR_CLEAR;
            MODE_FORCE_HI:    trans = TR_SET;
            MODE_PWM_A:       trans = below ? TR_SET   : TR_CLEAR;
            MODE_PWM_B:       trans = below ? TR_CLEAR : TR_SET;
        endcase
    end

    always_comb begin
        state_nx = state_q;
        unique case (trans)
            TR_HOLD:  state_nx = state_q;
            TR_SET:   state_nx = LVL_ACTIVE;
            TR_CLEAR: state_nx = LVL_INACTIVE;
            TR_FLIP:  state_nx = (state_q == LVL_ACTIVE) ? LVL_INACTIVE : LVL_ACTIVE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LVL_INACTIVE;
        end else begin
            state_q <= state_nx;
        end
    end

    // Output decode
    always_comb begin
        level_o = (state_q == LVL_ACTIVE);
    end

endmodule

// File: rtl/oc_evt_flag.sv
module oc_evt_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic match_i,
    input  logic clr_i,
    input  logic ien_i,
    output logic flag_o,
    output logic irq_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_o <= 1'b0;
        end else if (match_i) begin
            flag_o <= 1'b1;
        end else if (clr_i) begin
            flag_o <= 1'b0;
        end
    end

    assign irq_o = flag_o & ien_i;

endmodule

// File: rtl/oc_channel.sv
module oc_channel
    import oc_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] arr_i,
    input  logic [2:0]   mode_i,
    input  logic         preload_en_i,
    input  logic         cmp_wr_i,
    input  logic [W-1:0] cmp_wdata_i,
    input  logic         sw_update_i,
    input  logic         flag_clr_i,
    input  logic         irq_en_i,
    output logic [W-1:0] cnt_o,
    output logic [W-1:0] cmp_o,
    output logic         oc_out_o,
    output logic         flag_o,
    output logic         irq_o
);

    logic     upd;
    logic     match;
    oc_mode_e mode;

    assign mode  = oc_mode_e'(mode_i);
    assign match = (cnt_o == cmp_o);

    oc_upcnt #(.W(W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .arr_i    (arr_i),
        .sw_upd_i (sw_update_i),
        .cnt_o    (cnt_o),
        .upd_o    (upd)
    );

    oc_cmp_reg #(.W(W)) u_cmp (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (cmp_wr_i),
        .wdata_i   (cmp_wdata_i),
        .preload_i (preload_en_i),
        .upd_i     (upd),
        .active_o  (cmp_o)
    );

    oc_lvl_fsm #(.W(W)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_i  (mode),
        .cnt_i   (cnt_o),
        .cmp_i   (cmp_o),
        .match_i (match),
        .level_o (oc_out_o)
    );

    oc_evt_flag u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .match_i (match),
        .clr_i   (flag_clr_i),
        .ien_i   (irq_en_i),
        .flag_o  (flag_o),
        .irq_o   (irq_o)
    );

endmodule

// File: rtl/oc_channel_chk.sv
module oc_channel_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] arr_i,
    input logic [2:0]   mode_i,
    input logic         preload_en_i,
    input logic         sw_update_i,
    input logic [W-1:0] cnt_o,
    input logic [W-1:0] cmp_o,
    input logic         oc_out_o,
    input logic         flag_o
);

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_o != arr_i && !sw_update_i) |=> (cnt_o == $past(cnt_o) + 1'b1)); // R1

    AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_o == arr_i || sw_update_i) |=> (cnt_o == '0)); // R13

    AST_FLAG_ON_EQ: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_o == cmp_o) |=> flag_o); // R10

    AST_FLAG_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_o && cnt_o != cmp_o) |=> !flag_o); // R10

    AST_MATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_i == 3'b001 || mode_i == 3'b010 || mode_i == 3'b011) && cnt_o != cmp_o)
        |=> $stable(oc_out_o)); // R3

    AST_FORCE_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 3'b101) |=> oc_out_o); // R6

    AST_FORCE_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 3'b100) |=> !oc_out_o); // R6

    AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 3'b000) |=> $stable(oc_out_o)); // R7

    AST_PWM_A_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 3'b110) |=> (oc_out_o == ($past(cnt_o) < $past(cmp_o)))); // R8

    AST_PWM_B_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 3'b111) |=> (oc_out_o == ($past(cnt_o) >= $past(cmp_o)))); // R9

    AST_PRELOAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (preload_en_i && cnt_o != arr_i && !sw_update_i) |=> $stable(cmp_o)); // R12

endmodule

bind oc_channel oc_channel_chk #(.W(W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .arr_i        (arr_i),
    .mode_i       (mode_i),
    .preload_en_i (preload_en_i),
    .sw_update_i  (sw_update_i),
    .cnt_o        (cnt_o),
    .cmp_o        (cmp_o),
    .oc_out_o     (oc_out_o),
    .flag_o       (flag_o)
);

// File: tb/tb_oc_channel.sv
`timescale 1ns/1ps
module tb_oc_channel;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] arr_i = 16'd15;
    logic [2:0]   mode_i = 3'b100;
    logic         preload_en_i = 1'b0;
    logic         cmp_wr_i = 1'b0;
    logic [W-1:0] cmp_wdata_i = '0;
    logic         sw_update_i = 1'b0;
    logic         flag_clr_i = 1'b0;
    logic         irq_en_i = 1'b0;
    logic [W-1:0] cnt_o;
    logic [W-1:0] cmp_o;
    logic         oc_out_o;
    logic         flag_o;
    logic         irq_o;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    oc_channel #(.W(W)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .arr_i        (arr_i),
        .mode_i       (mode_i),
        .preload_en_i (preload_en_i),
        .cmp_wr_i     (cmp_wr_i),
        .cmp_wdata_i  (cmp_wdata_i),
        .sw_update_i  (sw_update_i),
        .flag_clr_i   (flag_clr_i),
        .irq_en_i     (irq_en_i),
        .cnt_o        (cnt_o),
        .cmp_o        (cmp_o),
        .oc_out_o     (oc_out_o),
        .flag_o       (flag_o),
        .irq_o        (irq_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wait_cnt(input int v);
        do @(negedge clk); while (cnt_o != v[W-1:0]);
    endtask

    // Write strobe captured at the next edge; returns one negedge later
    task automatic pulse_wr(input int v);
        cmp_wr_i    = 1'b1;
        cmp_wdata_i = v[W-1:0];
        @(negedge clk);
        cmp_wr_i    = 1'b0;
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        check("R2 cnt", int'(cnt_o), 0);
        check("R2 cmp", int'(cmp_o), 16'hFFFF);
        check("R2 out", int'(oc_out_o), 0);
        check("R2 flag", int'(flag_o), 0);
        check("R2 irq", int'(irq_o), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_counter;
        wait_cnt(15);
        @(negedge clk);
        check("R1 wrap to zero", int'(cnt_o), 0);
        @(negedge clk);
        check("R1 step after wrap", int'(cnt_o), 1);
    endtask

    task automatic t_active_match;
        wait_cnt(1);
        mode_i = 3'b100; flag_clr_i = 1'b1;
        @(negedge clk);
        flag_clr_i = 1'b0; mode_i = 3'b001;
        pulse_wr(8);
        check("R3 low before match", int'(oc_out_o), 0);
        wait_cnt(8);
        check("R3 low on match cycle", int'(oc_out_o), 0);
        @(negedge clk);
        check("R3 high after match", int'(oc_out_o), 1);
        check("R10 flag after match", int'(flag_o), 1);
    endtask

    task automatic t_missed;
        int bad = 0;
        wait_cnt(9);
        mode_i = 3'b100; flag_clr_i = 1'b1;
        @(negedge clk);
        flag_clr_i = 1'b0; mode_i = 3'b001;
        pulse_wr(5);
        while (cnt_o != 16'd5) begin
            if (oc_out_o !== 1'b0 || flag_o !== 1'b0) bad++;
            @(negedge clk);
        end
        check("R3 missed value leaves output low until wrap", bad, 0);
        @(negedge clk);
        check("R3 asserts when count returns", int'(oc_out_o), 1);
        check("R10 flag on returned match", int'(flag_o), 1);
    endtask

    task automatic t_inactive;
        mode_i = 3'b010; flag_clr_i = 1'b1;
        pulse_wr(12);
        flag_clr_i = 1'b0;
        check("R4 holds high before match", int'(oc_out_o), 1);
        wait_cnt(12);
        check("R4 high on match cycle", int'(oc_out_o), 1);
        @(negedge clk);
        check("R4 low after match", int'(oc_out_o), 0);
        check("R10 flag in mode 010", int'(flag_o), 1);
    endtask

    task automatic t_toggle;
        wait_cnt(13);
        mode_i = 3'b011;
        pulse_wr(3);
        wait_cnt(3);
        check("R5 before first match", int'(oc_out_o), 0);
        @(negedge clk);
        check("R5 first toggle", int'(oc_out_o), 1);
        wait_cnt(3);
        @(negedge clk);
        check("R5 second toggle", int'(oc_out_o), 0);
    endtask

    task automatic t_force;
        mode_i = 3'b101;
        @(negedge clk);
        check("R6 force high", int'(oc_out_o), 1);
        mode_i = 3'b100;
        @(negedge clk);
        check("R6 force low", int'(oc_out_o), 0);
    endtask

    task automatic t_frozen;
        int bad = 0;
        wait_cnt(8);
        mode_i = 3'b101;
        @(negedge clk);
        mode_i = 3'b000; flag_clr_i = 1'b1;
        @(negedge clk);
        flag_clr_i = 1'b0;
        for (int i = 0; i < 20; i++) begin
            if (oc_out_o !== 1'b1) bad++;
            @(negedge clk);
        end
        check("R7 frozen holds level across match", bad, 0);
        check("R10 flag sets in frozen mode", int'(flag_o), 1);
    endtask

    task automatic t_pwm_a;
        int bad = 0;
        int p;
        mode_i = 3'b110;
        pulse_wr(6);
        p = int'(cnt_o);
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            if (int'(oc_out_o) != ((p < 6) ? 1 : 0)) bad++;
            p = int'(cnt_o);
        end
        check("R8 PWM A level over one period", bad, 0);
    endtask

    task automatic t_pwm_b_late;
        int bad = 0;
        wait_cnt(1);
        mode_i = 3'b111;
        pulse_wr(15);
        @(negedge clk);
        check("R9 low while count below", int'(oc_out_o), 0);
        wait_cnt(10);
        check("R9 low at count 10", int'(oc_out_o), 0);
        flag_clr_i = 1'b1;
        pulse_wr(4);
        flag_clr_i = 1'b0;
        check("R9 not yet high", int'(oc_out_o), 0);
        @(negedge clk);
        check("R9 late value asserts next clock", int'(oc_out_o), 1);
        while (cnt_o != 16'd15) begin
            if (flag_o !== 1'b0) bad++;
            @(negedge clk);
        end
        check("R9 late value sets no flag", bad, 0);
    endtask

    task automatic t_preload;
        preload_en_i = 1'b1;
        wait_cnt(2);
        pulse_wr(9);
        check("R12 write goes to shadow only", int'(cmp_o), 4);
        wait_cnt(0);
        check("R12 shadow loaded on wrap", int'(cmp_o), 9);
    endtask

    task automatic t_sw_update;
        wait_cnt(3);
        pulse_wr(2);
        check("R12 shadow pending", int'(cmp_o), 9);
        wait_cnt(7);
        sw_update_i = 1'b1;
        @(negedge clk);
        sw_update_i = 1'b0;
        check("R13 counter cleared", int'(cnt_o), 0);
        check("R13 shadow loaded", int'(cmp_o), 2);
        @(negedge clk);
        check("R13 counting resumes", int'(cnt_o), 1);
    endtask

    task automatic t_irq;
        irq_en_i = 1'b0;
        wait_cnt(3);
        check("R11 flag present", int'(flag_o), 1);
        check("R11 masked", int'(irq_o), 0);
        irq_en_i = 1'b1;
        #1;
        check("R11 enabled", int'(irq_o), 1);
        flag_clr_i = 1'b1;
        @(negedge clk);
        flag_clr_i = 1'b0;
        check("R10 flag cleared", int'(flag_o), 0);
        check("R11 irq drops with flag", int'(irq_o), 0);
    endtask

    initial begin
        t_reset;
        t_counter;
        t_active_match;
        t_missed;
        t_inactive;
        t_toggle;
        t_force;
        t_frozen;
        t_pwm_a;
        t_pwm_b_late;
        t_preload;
        t_sw_update;
        t_irq;
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule